// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock, typically an oscillator output, by a programmable integer. It emits one pulse, one input-clock cycle wide, for each complete division cycle. Inside, a prescaler counts either eleven or ten input cycles per period. A main counter sets how many prescaler periods make up one division cycle. A swallow counter picks how many of those periods use the longer, eleven-cycle count. The resulting ratio is ten times the main-count length plus the swallow count.

A bypass setting removes the prescaler and the swallow counter from the chain, so the main counter divides the input clock directly by M+1. The main value, swallow value and bypass bit are sampled only on the input cycle that ends a division cycle. A value written in the middle of a cycle therefore never distorts the period under way. When the swallow value is larger than the main-count length, the block limits it to that length and raises an error flag for the division cycle that uses the limited value.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With bypass low, the spacing between successive output pulses is 10·(M+1)+A input cycles when A ≤ M+1 (for example M=2, A=1 gives 31).
- R2: With bypass high, the spacing between pulses is M+1 input cycles. M=0 gives a pulse on every cycle, and M=1 gives a spacing of 2.
- R3: With bypass low and A > M+1, A is limited to M+1, so the spacing becomes 11·(M+1). The error output is high while that division cycle runs and low for every setting that is in range.
- R4: M, A and bypass are taken only on the cycle where the output pulse is high, and they apply from the next cycle on. Changes made at any other point leave the current period's length unchanged.
- R5: While reset is held, the output pulse and the error output are low. The first pulse arrives N input cycles after reset is released, where N is the ratio set at release. When N ≥ 2, each pulse lasts exactly one input cycle.
- R6: The largest setting, M=511 with A=15 and bypass low, gives a spacing of 5135 cycles.
- R7: With bypass high, A has no effect on the pulse spacing, and the error output stays low even when A > M+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| mIn | input | 9 | Main counter value M |
| aIn | input | 4 | Swallow counter value A |
| bypassIn | input | 1 | High: divide directly by M+1 |
| divPulse | output | 1 | One-cycle pulse on the last input cycle of each division cycle |
| aClampErr | output | 1 | High while the current cycle uses a limited A |

## Verification
The hardest case to reach from the ports is a settings change that lands strictly inside a division cycle. The block only ever shows its period boundaries, so the stimulus has to follow pulse timing exactly. The bench waits for a pulse, counts a few cycles into the next period, and then rewrites M, A and bypass. It checks that the period already running keeps its old length and that the following period takes the new one. A second hard case is the period that uses the clamped swallow value. The bench reaches it with random and directed settings where A exceeds M+1, including M=0.

// File: rtl/divider_pkg.sv
package divider_pkg;
  // Strobes from the sequencing control to the counting datapath.
  typedef struct packed {
    logic load;      // take new settings and restart the division cycle
    logic mStep;     // prescaler period finished, main counter advances
    logic aStep;     // swallow counter advances together with mStep
    logic terminal;  // last input cycle of the division cycle
  } divStrobes_t;
endpackage

// File: rtl/dual_mod_datapath.sv
module dual_mod_datapath
  import divider_pkg::*;
#(
  parameter int M_W    = 9,
  parameter int A_W    = 4,
  parameter int P_BASE = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [M_W-1:0] mIn,
  input  logic [A_W-1:0] aIn,
  input  logic           bypassIn,
  input  divStrobes_t    strb,
  output logic           primed,
  output logic           mZero,
  output logic           preZero,
  output logic           aZero,
  output logic           cfgByp,
  output logic           errOut
);
  localparam int PRE_W = $clog2(P_BASE + 1);
  localparam int CMP_W = M_W + 1;
  localparam logic [PRE_W-1:0] PRE_LONG  = PRE_W'(P_BASE);
  localparam logic [PRE_W-1:0] PRE_SHORT = PRE_W'(P_BASE - 1);

  logic [M_W-1:0]   cfgM;
  logic [A_W-1:0]   cfgA;
  logic [M_W-1:0]   mCnt;
  logic [A_W-1:0]   aCnt;
  logic [PRE_W-1:0] preCnt;

  logic [CMP_W-1:0] mPlusOne;
  logic             aOver;
  logic [A_W-1:0]   aEff;
  logic [A_W-1:0]   aNext;

  // Limit the swallow value to the main-count length.
  always_comb begin
    mPlusOne = {1'b0, mIn} + CMP_W'(1);
    aOver    = CMP_W'(aIn) > mPlusOne;
    aEff     = aOver ? mPlusOne[A_W-1:0] : aIn;
    aNext    = strb.aStep ? aCnt - A_W'(1) : aCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      cfgM   <= '0;
      cfgA   <= '0;
      cfgByp <= 1'b0;
      errOut <= 1'b0;
      mCnt   <= '0;
      aCnt   <= '0;
      preCnt <= '0;
    end else if (strb.load) begin
      primed <= 1'b1;
      cfgM   <= mIn;
      cfgA   <= bypassIn ? '0 : aEff;
      cfgByp <= bypassIn;
      errOut <= !bypassIn && aOver;
      mCnt   <= mIn;
      aCnt   <= bypassIn ? '0 : aEff;
      if (bypassIn)        preCnt <= '0;
      else if (aEff != '0) preCnt <= PRE_LONG;
      else                 preCnt <= PRE_SHORT;
    end else if (strb.mStep) begin
      mCnt <= mCnt - M_W'(1);
      aCnt <= aNext;
      if (!cfgByp) preCnt <= (aNext != '0) ? PRE_LONG : PRE_SHORT;
    end else if (primed && !cfgByp) begin
      preCnt <= preCnt - PRE_W'(1);
    end
  end

  assign mZero   = (mCnt == '0);
  assign preZero = (preCnt == '0);
  assign aZero   = (aCnt == '0);

  // R4: settings only change at a load strobe.
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(cfgM) && $stable(cfgA) && $stable(cfgByp)));

  // R3: the swallow value in use never exceeds the main-count length.
  p_a_clamped_r3: assert property (@(posedge clk) disable iff (!rstN)
    CMP_W'(cfgA) <= ({1'b0, cfgM} + CMP_W'(1)));

  // R3/R7: the error flag is only ever raised in normal mode.
  p_err_normal_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> !cfgByp);

  // R1: in normal mode the main counter only moves at a prescaler wrap.
  p_m_on_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !strb.load && !cfgByp && !preZero) |=> (mCnt == $past(mCnt)));
endmodule

// File: rtl/dual_mod_ctrl.sv
module dual_mod_ctrl
  import divider_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        primed,
  input  logic        mZero,
  input  logic        preZero,
  input  logic        aZero,
  input  logic        cfgByp,
  output divStrobes_t strb
);
  logic periodEnd;

  always_comb begin
    // A prescaler period ends every cycle in bypass, else on the wrap.
    periodEnd     = primed && (cfgByp || preZero);
    strb.terminal = periodEnd && mZero;
    strb.load     = !primed || strb.terminal;
    strb.mStep    = periodEnd && !mZero;
    strb.aStep    = strb.mStep && !cfgByp && !aZero;
  end

  // R5: a pulse never lasts two cycles unless the new setting divides by 1.
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.terminal |=> (!strb.terminal || (cfgByp && mZero)));

  // R1: the swallow counter only moves with the main counter.
  p_a_with_m_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.aStep |-> (strb.mStep && !strb.load));
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import divider_pkg::*;
#(
  parameter int M_W    = 9,
  parameter int A_W    = 4,
  parameter int P_BASE = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [M_W-1:0] mIn,
  input  logic [A_W-1:0] aIn,
  input  logic           bypassIn,
  output logic           divPulse,
  output logic           aClampErr
);
  divStrobes_t strb;
  logic primed, mZero, preZero, aZero, cfgByp;

  dual_mod_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .primed(primed), .mZero(mZero),
    .preZero(preZero), .aZero(aZero), .cfgByp(cfgByp), .strb(strb)
  );

  dual_mod_datapath #(.M_W(M_W), .A_W(A_W), .P_BASE(P_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .mIn(mIn), .aIn(aIn), .bypassIn(bypassIn),
    .strb(strb), .primed(primed), .mZero(mZero), .preZero(preZero),
    .aZero(aZero), .cfgByp(cfgByp), .errOut(aClampErr)
  );

  assign divPulse = strb.terminal;
endmodule

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] mIn = '0;
  logic [3:0] aIn = '0;
  logic       bypassIn = 1'b0;
  logic       divPulse, aClampErr;
  int         nTests = 0;
  int         nFail = 0;

  always #10 clk = ~clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rstN(rstN), .mIn(mIn), .aIn(aIn), .bypassIn(bypassIn),
    .divPulse(divPulse), .aClampErr(aClampErr)
  );

  function automatic int expRatio(int m, int a, bit byp);
    int ae;
    if (byp) return m + 1;
    ae = (a > m + 1) ? m + 1 : a;
    return 10 * (m + 1) + ae;
  endfunction

  function automatic bit expErr(int m, int a, bit byp);
    return !byp && (a > m + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitPulse();
    do @(negedge clk); while (!divPulse);
  endtask

  task automatic measureNext(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!divPulse);
  endtask

  task automatic setCfg(int m, int a, bit byp);
    mIn = 9'(m); aIn = 4'(a); bypassIn = byp;
  endtask

  task automatic runCase(string req, int m, int a, bit byp);
    int n;
    setCfg(m, a, byp);
    waitPulse();
    measureNext(n);
    check(req, n, expRatio(m, a, byp));
    check(req, int'(aClampErr), int'(expErr(m, a, byp)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    setCfg(2, 1, 1'b0);
    repeat (3) @(negedge clk);
    check("R5 reset pulse", int'(divPulse), 0);
    check("R5 reset err", int'(aClampErr), 0);
    rstN = 1'b1;
    measureNext(n);
    check("R5 first pulse", n, 31);
    @(negedge clk);
    check("R5 pulse width", int'(divPulse), 0);
    // R1 directed
    runCase("R1", 2, 1, 1'b0);
    runCase("R1", 14, 15, 1'b0);
    runCase("R1", 5, 0, 1'b0);
    // R2 bypass
    runCase("R2", 0, 0, 1'b1);
    runCase("R2", 1, 0, 1'b1);
    runCase("R2", 37, 0, 1'b1);
    // R3 clamp
    runCase("R3", 5, 15, 1'b0);
    runCase("R3", 0, 15, 1'b0);
    runCase("R3 err clears", 20, 3, 1'b0);
    // R7 A ignored in bypass
    runCase("R7", 3, 15, 1'b1);
    runCase("R7", 3, 0, 1'b1);
    // R6 extreme
    runCase("R6", 511, 15, 1'b0);
    // R4 mid-period change
    setCfg(3, 2, 1'b0);
    waitPulse();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 3) setCfg(6, 4, 1'b0);
    end while (!divPulse);
    check("R4 old period kept", n, 42);
    measureNext(n);
    check("R4 new period", n, 74);
    // constrained random
    for (int i = 0; i < 40; i++) begin
      int m, a;
      bit byp;
      m = int'($urandom % 64);
      a = int'($urandom % 16);
      byp = ($urandom % 4) == 0;
      runCase(byp ? "R2/R7 random" : "R1/R3 random", m, a, byp);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule